// File: doc/BRIEF.md
# Strided and Fragmented Read Request Sequencer

This block turns a descriptor that has already been checked into a run of memory read requests. Each request is a byte address and a byte length, offered on a valid/ready handshake. One load pulse captures the transfer size, the packed line-size/stride word, the fragment-select bit and the source address fields. The block then issues requests until the transfer is covered, a read error response arrives, or the line geometry is found to be unusable.

Two walking modes exist. In the contiguous mode the block steps through a two-dimensional frame: each request is one line long, and the next line starts one stride further on. In the fragmented mode the block visits up to five separate source buffers in turn. Each request stops at the next 4096-byte page boundary and is clipped to what remains of the transfer. The block moves no data and parses no descriptor. It only sequences the requests.

Top module: `rd_req_sequencer`

## Requirements
- R1: After reset, busy_o, req_valid_o, done_o, shape_err_o and data_err_o are all 0.
- R2: In contiguous mode the line size is shape_i[17:0] and the stride in bytes is shape_i[31:18] times 16. Request k has address base0 + k*stride and length equal to the line size, and the block issues total_i / line size requests.
- R3: The base address of fragment k is src_lo_i[32k+31:32k] plus (src_ext_i[12k+11:12k] shifted left by 20). Contiguous mode starts at the base of fragment 0.
- R4: In fragmented mode the block requests fragments 0, 1, 2 and so on, in that order, each at its base. Each length is the smaller of (4096 - address mod 4096) and the remaining size. The sequence ends when the remaining size is zero or after five fragments.
- R5: frag_sel_i is sampled at load and selects the mode (1 = fragmented, 0 = contiguous). It carries descriptor control bit 18.
- R6: While req_valid_o is 1 and req_ready_i is 0, the request address and length stay unchanged into the next cycle.
- R7: busy_o is 1 from the cycle after an accepted load until the final request is accepted. done_o is a one-cycle pulse in the cycle after that acceptance, with busy_o already 0.
- R8: A pulse on rd_err_i while busy stops the sequence. data_err_o pulses in the next cycle, and no further request is offered. If rd_err_i and an acceptance fall in the same cycle, the error wins.
- R9: In contiguous mode, a line size of 0, or a remainder that is nonzero and smaller than the line size, ends the sequence with a shape_err_o pulse. When this happens, the block has already issued all whole lines, so floor(total_i / line size) requests.
- R10: A load pulse while busy is ignored, and the running sequence continues unchanged.
- R11: A load with total_i = 0 issues no request, and done_o pulses two cycles after the load edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_i | input | 1 | Capture the descriptor fields and start a sequence |
| frag_sel_i | input | 1 | 1 selects fragmented mode, 0 selects contiguous mode |
| total_i | input | 32 | Total transfer size in bytes |
| shape_i | input | 32 | Packed word: line size in bits 17:0, stride in 16-byte units in bits 31:18 |
| src_lo_i | input | 160 | Five 32-bit low address words, fragment k in bits 32k+31:32k |
| src_ext_i | input | 60 | Five 12-bit address extensions, fragment k in bits 12k+11:12k |
| req_valid_o | output | 1 | A read request is offered |
| req_ready_i | input | 1 | The request is taken in this cycle |
| req_addr_o | output | 44 | Request byte address |
| req_len_o | output | 32 | Request byte length |
| rd_err_i | input | 1 | Error response for a data read |
| busy_o | output | 1 | A sequence is in progress |
| done_o | output | 1 | Pulse: the sequence completed normally |
| shape_err_o | output | 1 | Pulse: the contiguous line geometry is unusable |
| data_err_o | output | 1 | Pulse: the sequence was stopped by a read error |

## Verification
A wrong remaining-size register shows at the ports within the same request. It appears as an extra or missing request, as a last fragment that is not clipped, or as a shape error where none is due. A stride or fragment index that is off appears as a wrong req_addr_o at the very next accepted request. A completion or error flag that fires late, early or twice appears against busy_o in the cycle right after the last handshake. This makes the cycle of the end pulse, and not just its presence, the sharpest observation.

// File: rtl/rrs_pkg.sv
package rrs_pkg;
  localparam int ADDR_W    = 44;
  localparam int LEN_W     = 32;
  localparam int EXT_W     = 12;
  localparam int EXT_SHIFT = 20;

  // line size: low 18 bits of the packed geometry word
  function automatic logic [LEN_W-1:0] line_of(input logic [31:0] w);
    return LEN_W'(w[17:0]);
  endfunction

  // stride: upper 14 bits in 16-byte units
  function automatic logic [LEN_W-1:0] stride_of(input logic [31:0] w);
    return LEN_W'({w[31:18], 4'b0000});
  endfunction

  function automatic logic [ADDR_W-1:0] base_of(input logic [31:0] lo,
                                                input logic [EXT_W-1:0] ext);
    return ADDR_W'(lo) + (ADDR_W'(ext) << EXT_SHIFT);
  endfunction

  // bytes left before the next page boundary
  function automatic logic [LEN_W-1:0] page_room(input logic [ADDR_W-1:0] a,
                                                 input int unsigned plog2);
    logic [LEN_W-1:0] page;
    logic [LEN_W-1:0] offs;
    page = LEN_W'(1) << plog2;
    offs = LEN_W'(a) & (page - LEN_W'(1));
    return page - offs;
  endfunction
endpackage

// File: rtl/rrs_frag_table.sv
module rrs_frag_table
  import rrs_pkg::*;
#(
  parameter int NFRAG = 5,
  parameter int IDX_W = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   capture,
  input  logic [NFRAG*32-1:0]    lo_flat,
  input  logic [NFRAG*EXT_W-1:0] ext_flat,
  input  logic [IDX_W-1:0]       sel,
  output logic [ADDR_W-1:0]      base
);
  logic [ADDR_W-1:0] cand  [NFRAG];
  logic [ADDR_W-1:0] bases [NFRAG];

  for (genvar g = 0; g < NFRAG; g++) begin : g_slot
    assign cand[g] = base_of(lo_flat[g*32 +: 32], ext_flat[g*EXT_W +: EXT_W]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NFRAG; i++) bases[i] <= '0;
    end else if (capture) begin
      bases <= cand;
    end
  end

  always_comb begin
    base = '0;
    for (int i = 0; i < NFRAG; i++)
      if (sel == IDX_W'(i)) base = bases[i];
  end
endmodule

// File: rtl/rrs_len_calc.sv
module rrs_len_calc
  import rrs_pkg::*;
#(
  parameter int PAGE_LOG2 = 12
) (
  input  logic              frag_mode,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LEN_W-1:0]  rem,
  input  logic [LEN_W-1:0]  line,
  output logic [LEN_W-1:0]  len,
  output logic              shape_ok,
  output logic              ends
);
  logic [LEN_W-1:0] room;

  always_comb begin
    room = page_room(addr, PAGE_LOG2);
    if (frag_mode) begin
      len      = (room < rem) ? room : rem;
      shape_ok = 1'b1;
    end else begin
      len      = line;
      shape_ok = (line != '0) && (rem >= line);
    end
    ends = (len == rem);
  end
endmodule

// File: rtl/rrs_walker.sv
module rrs_walker
  import rrs_pkg::*;
#(
  parameter int NFRAG = 5,
  parameter int IDX_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              frag_in,
  input  logic [LEN_W-1:0]  total_in,
  input  logic [LEN_W-1:0]  line_in,
  input  logic [LEN_W-1:0]  stride_in,
  input  logic              ready,
  input  logic              rd_err,
  input  logic [LEN_W-1:0]  len,
  input  logic              shape_ok,
  input  logic              ends,
  output logic              valid,
  output logic              capture,
  output logic              frag_q,
  output logic [LEN_W-1:0]  rem_q,
  output logic [LEN_W-1:0]  line_q,
  output logic [ADDR_W-1:0] off_q,
  output logic [IDX_W-1:0]  idx_q,
  output logic              busy,
  output logic              done,
  output logic              shape_err,
  output logic              data_err
);
  logic [LEN_W-1:0] stride_q;
  logic             accept;
  logic             last_frag;
  logic             final_step;

  assign capture    = load && !busy;
  assign valid      = busy && (rem_q != '0) && shape_ok;
  assign accept     = valid && ready && !rd_err;
  assign last_frag  = (idx_q == IDX_W'(NFRAG-1));
  assign final_step = accept && (ends || (frag_q && last_frag));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0; frag_q <= 1'b0; rem_q <= '0; line_q <= '0;
      stride_q <= '0; off_q <= '0; idx_q <= '0;
      done <= 1'b0; shape_err <= 1'b0; data_err <= 1'b0;
    end else begin
      done <= 1'b0; shape_err <= 1'b0; data_err <= 1'b0;
      if (!busy) begin
        if (load) begin
          busy <= 1'b1; frag_q <= frag_in; rem_q <= total_in;
          line_q <= line_in; stride_q <= stride_in;
          off_q <= '0; idx_q <= '0;
        end
      end else if (rd_err) begin
        busy <= 1'b0; data_err <= 1'b1;
      end else if (rem_q == '0) begin
        busy <= 1'b0; done <= 1'b1;
      end else if (!shape_ok) begin
        busy <= 1'b0; shape_err <= 1'b1;
      end else if (accept) begin
        rem_q <= rem_q - len;
        off_q <= off_q + ADDR_W'(stride_q);
        if (frag_q) idx_q <= idx_q + IDX_W'(1);
        if (final_step) begin
          busy <= 1'b0; done <= 1'b1;
        end
      end
    end
  end

  // R9: an offered request never exceeds what remains
  assert_len_fits_R9: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> (len <= rem_q));
endmodule

// File: rtl/rd_req_sequencer.sv
module rd_req_sequencer
  import rrs_pkg::*;
#(
  parameter int NFRAG     = 5,
  parameter int PAGE_LOG2 = 12
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   load_i,
  input  logic                   frag_sel_i,
  input  logic [31:0]            total_i,
  input  logic [31:0]            shape_i,
  input  logic [NFRAG*32-1:0]    src_lo_i,
  input  logic [NFRAG*EXT_W-1:0] src_ext_i,
  output logic                   req_valid_o,
  input  logic                   req_ready_i,
  output logic [ADDR_W-1:0]      req_addr_o,
  output logic [LEN_W-1:0]       req_len_o,
  input  logic                   rd_err_i,
  output logic                   busy_o,
  output logic                   done_o,
  output logic                   shape_err_o,
  output logic                   data_err_o
);
  localparam int IDX_W = $clog2(NFRAG + 1);

  logic              capture_w;
  logic              frag_q;
  logic [LEN_W-1:0]  rem_q;
  logic [LEN_W-1:0]  line_q;
  logic [ADDR_W-1:0] off_q;
  logic [IDX_W-1:0]  idx_q;
  logic [IDX_W-1:0]  sel_w;
  logic [ADDR_W-1:0] base_w;
  logic [LEN_W-1:0]  len_w;
  logic              shape_ok_w;
  logic              ends_w;

  assign sel_w      = frag_q ? idx_q : '0;
  assign req_addr_o = base_w + (frag_q ? '0 : off_q);
  assign req_len_o  = len_w;

  rrs_frag_table #(.NFRAG(NFRAG), .IDX_W(IDX_W)) u_table (
    .clk(clk), .rst_n(rst_n), .capture(capture_w),
    .lo_flat(src_lo_i), .ext_flat(src_ext_i), .sel(sel_w), .base(base_w)
  );

  rrs_len_calc #(.PAGE_LOG2(PAGE_LOG2)) u_len (
    .frag_mode(frag_q), .addr(req_addr_o), .rem(rem_q), .line(line_q),
    .len(len_w), .shape_ok(shape_ok_w), .ends(ends_w)
  );

  rrs_walker #(.NFRAG(NFRAG), .IDX_W(IDX_W)) u_walk (
    .clk(clk), .rst_n(rst_n), .load(load_i), .frag_in(frag_sel_i),
    .total_in(total_i), .line_in(line_of(shape_i)), .stride_in(stride_of(shape_i)),
    .ready(req_ready_i), .rd_err(rd_err_i), .len(len_w),
    .shape_ok(shape_ok_w), .ends(ends_w), .valid(req_valid_o),
    .capture(capture_w), .frag_q(frag_q), .rem_q(rem_q), .line_q(line_q),
    .off_q(off_q), .idx_q(idx_q), .busy(busy_o), .done(done_o),
    .shape_err(shape_err_o), .data_err(data_err_o)
  );

  // R6: a stalled request holds its address and length
  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_o && !req_ready_i && !rd_err_i) |=>
      (req_valid_o && $stable(req_addr_o) && $stable(req_len_o)));

  // R4: a fragment request never crosses a page boundary
  assert_page_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_o && frag_q) |->
      ((64'(req_addr_o[PAGE_LOG2-1:0]) + 64'(req_len_o)) <= (64'(1) << PAGE_LOG2)));

  // R7: completion is reported only once the block is idle
  assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);

  // R8: end events are exclusive and an error leaves nothing offered
  assert_end_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done_o, shape_err_o, data_err_o}));
  assert_err_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    data_err_o |-> !req_valid_o);
endmodule

// File: tb/tb_rd_req_sequencer.sv
module tb_rd_req_sequencer;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         load_i = 1'b0;
  logic         frag_sel_i = 1'b0;
  logic [31:0]  total_i = '0;
  logic [31:0]  shape_i = '0;
  logic [159:0] src_lo_i = '0;
  logic [59:0]  src_ext_i = '0;
  logic         req_valid_o;
  logic         req_ready_i = 1'b0;
  logic [43:0]  req_addr_o;
  logic [31:0]  req_len_o;
  logic         rd_err_i = 1'b0;
  logic         busy_o, done_o, shape_err_o, data_err_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  rd_req_sequencer dut (
    .clk(clk), .rst_n(rst_n), .load_i(load_i), .frag_sel_i(frag_sel_i),
    .total_i(total_i), .shape_i(shape_i), .src_lo_i(src_lo_i),
    .src_ext_i(src_ext_i), .req_valid_o(req_valid_o), .req_ready_i(req_ready_i),
    .req_addr_o(req_addr_o), .req_len_o(req_len_o), .rd_err_i(rd_err_i),
    .busy_o(busy_o), .done_o(done_o), .shape_err_o(shape_err_o),
    .data_err_o(data_err_o)
  );

  int n_tests = 0;
  int n_fail  = 0;
  logic [31:0] lo [5];
  logic [11:0] ext[5];
  logic [63:0] got_addr[16], got_len[16], exp_addr[16], exp_len[16];
  int n_got, exp_n, outcome;

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] fbase(input int k);
    return 64'(lo[k]) + (64'(ext[k]) * 64'h10_0000);
  endfunction

  task automatic set_src();
    for (int k = 0; k < 5; k++) begin
      src_lo_i[k*32 +: 32] = lo[k];
      src_ext_i[k*12 +: 12] = ext[k];
    end
  endtask

  task automatic do_load(input bit fs, input logic [31:0] tot, input logic [31:0] shp);
    @(negedge clk);
    frag_sel_i = fs; total_i = tot; shape_i = shp; set_src();
    load_i = 1'b1;
    @(negedge clk);
    load_i = 1'b0;
  endtask

  task automatic contig_expect(input logic [63:0] line, input logic [63:0] stride, input logic [63:0] tot);
    exp_n = (line == 0) ? 0 : int'(tot / line);
    for (int k = 0; k < exp_n && k < 16; k++) begin
      exp_addr[k] = fbase(0) + 64'(k) * stride;
      exp_len[k]  = line;
    end
  endtask

  task automatic frag_expect(input logic [63:0] tot);
    logic [63:0] rem, a, room, l;
    rem = tot; exp_n = 0;
    for (int k = 0; k < 5; k++) begin
      if (rem != 0) begin
        a = fbase(k);
        room = 64'd4096 - (a % 64'd4096);
        l = (room < rem) ? room : rem;
        exp_addr[exp_n] = a; exp_len[exp_n] = l;
        exp_n++; rem = rem - l;
      end
    end
  endtask

  task automatic run_seq(input int rdy_every, input int err_at, input bit poke);
    bit hold, busy_bad, hold_bad;
    logic [43:0] h_addr;
    logic [31:0] h_len, saved;
    n_got = 0; outcome = -1; hold = 0; busy_bad = 0; hold_bad = 0;
    saved = total_i; h_addr = '0; h_len = '0;
    for (int c = 0; c < 400; c++) begin
      @(negedge clk);
      if (hold && !(req_valid_o && req_addr_o == h_addr && req_len_o == h_len)) hold_bad = 1;
      if (done_o || shape_err_o || data_err_o) begin
        outcome = done_o ? 0 : (shape_err_o ? 1 : 2);
        check(busy_o == 1'b0, "R7 busy low with end pulse", 64'(busy_o), 0);
        if (data_err_o) check(req_valid_o == 1'b0, "R8 no request after error", 64'(req_valid_o), 0);
        break;
      end
      if (!busy_o) busy_bad = 1;
      if (poke) begin
        load_i  = (c == 2);
        total_i = (c == 2) ? 32'd4096 : saved;
      end
      if (err_at >= 0 && n_got == err_at && req_valid_o) begin
        rd_err_i = 1'b1; req_ready_i = 1'b0;
      end else begin
        rd_err_i = 1'b0;
        req_ready_i = (rdy_every <= 1) || (c % rdy_every == 0);
      end
      hold = req_valid_o && !req_ready_i && !rd_err_i;
      h_addr = req_addr_o; h_len = req_len_o;
      if (req_valid_o && req_ready_i && !rd_err_i && n_got < 16) begin
        got_addr[n_got] = 64'(req_addr_o); got_len[n_got] = 64'(req_len_o);
        n_got++;
      end
    end
    rd_err_i = 1'b0; req_ready_i = 1'b0; load_i = 1'b0;
    check(!busy_bad, "R7 busy held until final acceptance", 64'(busy_bad), 0);
    check(!hold_bad, "R6 stalled request held stable", 64'(hold_bad), 0);
  endtask

  task automatic compare(input string req, input int exp_out);
    check(n_got == exp_n, {req, " request count"}, 64'(n_got), 64'(exp_n));
    for (int i = 0; i < exp_n && i < n_got; i++) begin
      check(got_addr[i] == exp_addr[i], {req, " request address"}, got_addr[i], exp_addr[i]);
      check(got_len[i] == exp_len[i], {req, " request length"}, got_len[i], exp_len[i]);
    end
    check(outcome == exp_out, {req, " end event (0 done,1 shape,2 data)"}, 64'(outcome), 64'(exp_out));
  endtask

  task automatic default_src();
    lo[0] = 32'h1000_0000; ext[0] = 12'h003;
    lo[1] = 32'h0002_0000; ext[1] = 12'h002;
    lo[2] = 32'h0003_0800; ext[2] = 12'h000;
    lo[3] = 32'h0004_0FFC; ext[3] = 12'h000;
    lo[4] = 32'h0005_0000; ext[4] = 12'h007;
    lo[0] = 32'h0000_0F00; ext[0] = 12'h001;
  endtask

  // shape: line 64 bytes, stride field 16 -> 256 bytes
  localparam logic [31:0] SHAPE_A = (32'd16 << 18) | 32'd64;
  localparam logic [31:0] SHAPE_B = (32'd5 << 18) | 32'd32;

  task automatic t_reset();
    @(negedge clk);
    check(!busy_o && !req_valid_o && !done_o && !shape_err_o && !data_err_o,
          "R1 idle after reset",
          64'({busy_o, req_valid_o, done_o, shape_err_o, data_err_o}), 0);
  endtask

  task automatic t_contig();
    do_load(1'b0, 32'd256, SHAPE_A);
    run_seq(1, -1, 0);
    contig_expect(64, 256, 256);
    compare("R2 R3 R5 contiguous walk", 0);
  endtask

  task automatic t_contig_stall();
    do_load(1'b0, 32'd160, SHAPE_B);
    run_seq(3, -1, 0);
    contig_expect(32, 80, 160);
    compare("R2 R6 contiguous under backpressure", 0);
  endtask

  task automatic t_frag_full();
    do_load(1'b1, 32'h0001_0000, SHAPE_A);
    run_seq(2, -1, 0);
    frag_expect(64'h0001_0000);
    compare("R4 R3 R5 five fragments", 0);
    check(exp_n == 5, "R4 five fragment limit", 64'(exp_n), 5);
  endtask

  task automatic t_frag_clip();
    do_load(1'b1, 32'h0000_0300, SHAPE_A);
    run_seq(1, -1, 0);
    frag_expect(64'h0000_0300);
    compare("R4 clipped last fragment", 0);
  endtask

  task automatic t_rd_err();
    do_load(1'b0, 32'd256, SHAPE_A);
    run_seq(1, 1, 0);
    contig_expect(64, 256, 64);
    compare("R8 read error stops sequence", 2);
  endtask

  task automatic t_shape();
    do_load(1'b0, 32'd100, SHAPE_B);
    run_seq(1, -1, 0);
    contig_expect(32, 80, 100);
    compare("R9 non-multiple size", 1);
    do_load(1'b0, 32'd100, 32'd16 << 18);
    run_seq(1, -1, 0);
    exp_n = 0;
    compare("R9 zero line size", 1);
  endtask

  task automatic t_load_busy();
    do_load(1'b0, 32'd256, SHAPE_A);
    run_seq(1, -1, 1);
    contig_expect(64, 256, 256);
    compare("R10 load while busy ignored", 0);
  endtask

  task automatic t_zero();
    do_load(1'b1, 32'd0, SHAPE_A);
    check(busy_o == 1'b1 && req_valid_o == 1'b0, "R11 busy without request",
          64'({busy_o, req_valid_o}), 64'h2);
    @(negedge clk);
    check(done_o == 1'b1 && busy_o == 1'b0, "R11 done two cycles after load",
          64'({done_o, busy_o}), 64'h2);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    default_src();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_contig();
    t_contig_stall();
    t_frag_full();
    t_frag_clip();
    t_rd_err();
    t_shape();
    t_load_busy();
    t_zero();
    repeat (3) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule